// File: doc/BRIEF.md
# Direct-Mapped Write-Through Data Cache

This block is an 8 KiB data cache placed between a processor and a slower main memory. The processor side is one 32-bit word wide and takes byte addresses. It holds a request until the stall output goes low, and the access completes in that cycle. The memory side has a single request/ready handshake. Reads move a whole 32-byte line in one transfer. Writes move one word each.

The cache keeps 256 lines of eight words, and each line has its own tag and valid bit. Every processor write is posted into a four-entry FIFO. The FIFO drains to memory in the background, so read hits keep running while earlier stores are still in flight. A write that misses does not allocate a line. A read that misses waits until the FIFO is empty, then fetches the line, and is served as a hit in the cycle after the fill.

Top module: `wt_dcache`

## Requirements
- R1: After reset every line is invalid, `mem_req` is low, and with no processor request `cpu_stall` is low. The first read of any address is therefore a miss.
- R2: Address bits [4:2] select the word inside a line, bits [12:5] select the line, and bits [31:13] form the tag. A read hits only when the selected line is valid and its stored tag equals the address tag. A read hit completes in the same cycle, with no stall, and returns the addressed word.
- R3: A read miss holds `cpu_stall` high. The fill request has `mem_we` low and `mem_addr` set to the line base (bits [4:0] zero). Word k of the line arrives on `mem_rdata[32k+31:32k]` in the cycle `mem_ready` is high. The stall drops in the next cycle, when the read completes as a hit.
- R4: Every completed read returns the value of the most recent accepted write to that word, or the memory's content if that word was never written.
- R5: Every accepted write reaches memory as one request with `mem_we` high, the word address (bits [1:0] zero) and the data. Writes reach memory in the order they were accepted.
- R6: A write miss allocates no line, so a later read of that line is still a miss.
- R7: A write hit updates the cached word in the same cycle it is accepted, so a following read hit returns the new value without a fill.
- R8: Up to four writes may be pending. A write is accepted without stall while fewer than four are pending, and it stalls while four are pending.
- R9: No line fill is requested while any write is still pending.
- R10: A read hit completes without stall while writes are still pending.
- R11: A fill replaces whatever line held that index, so the displaced address misses on its next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor access request, held until not stalled |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 32 | Write word |
| cpu_rdata | output | 32 | Read word, valid when a read completes |
| cpu_stall | output | 1 | Access cannot complete this cycle |
| mem_req | output | 1 | Memory request, held until ready |
| mem_we | output | 1 | 1 = word write, 0 = line read |
| mem_addr | output | 32 | Word address for writes, line base for reads |
| mem_wdata | output | 32 | Write word |
| mem_rdata | input | 256 | Fill line |
| mem_ready | input | 1 | Memory completes the current request this cycle |

## Verification
A read hit and the stall decision are combinational, so both are due in the same cycle the request is driven. A fill's effect is due one cycle after the edge where `mem_ready` is seen. A posted write shows up on the memory port once every earlier write has drained. The bench drives inputs on the falling edge. It settles them, then compares `cpu_stall`, the memory request fields and completed read data against a behavioural model advanced once per rising edge. Each result is therefore checked in exactly the cycle it is due. Memory latency is varied per access so the FIFO both fills and empties.

// File: rtl/wt_dcache.sv
module wt_dcache #(
  parameter int ADDR_W   = 32,
  parameter int WORD_W   = 32,
  parameter int WORDS    = 8,
  parameter int LINES    = 256,
  parameter int WB_DEPTH = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cpu_req,
  input  logic                    cpu_we,
  input  logic [ADDR_W-1:0]       cpu_addr,
  input  logic [WORD_W-1:0]       cpu_wdata,
  output logic [WORD_W-1:0]       cpu_rdata,
  output logic                    cpu_stall,
  output logic                    mem_req,
  output logic                    mem_we,
  output logic [ADDR_W-1:0]       mem_addr,
  output logic [WORD_W-1:0]       mem_wdata,
  input  logic [WORD_W*WORDS-1:0] mem_rdata,
  input  logic                    mem_ready
);
  localparam int OFF_W  = $clog2(WORD_W / 8);
  localparam int WSEL_W = $clog2(WORDS);
  localparam int IDX_W  = $clog2(LINES);
  localparam int TAG_W  = ADDR_W - IDX_W - WSEL_W - OFF_W;
  localparam int LINE_W = WORD_W * WORDS;
  localparam int PTR_W  = (WB_DEPTH > 1) ? $clog2(WB_DEPTH) : 1;
  localparam int CNT_W  = $clog2(WB_DEPTH + 1);

  logic [LINE_W-1:0] data_q [LINES];
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [LINES-1:0]  valid_q;

  logic [ADDR_W-1:0] wb_addr [WB_DEPTH];
  logic [WORD_W-1:0] wb_data [WB_DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [CNT_W-1:0]  wb_count;
  logic              fill_q;

  logic [IDX_W-1:0]  idx;
  logic [WSEL_W-1:0] wsel;
  logic [TAG_W-1:0]  tag;
  logic              hit, full, push, pop, fill_start, fill_done;
  logic [LINE_W-1:0] line_rd;
  logic              unused_lo;

  assign idx       = cpu_addr[OFF_W+WSEL_W +: IDX_W];
  assign wsel      = cpu_addr[OFF_W +: WSEL_W];
  assign tag       = cpu_addr[ADDR_W-1 -: TAG_W];
  assign unused_lo = ^cpu_addr[OFF_W-1:0];

  assign hit       = valid_q[idx] && (tag_q[idx] == tag);
  assign full      = (wb_count == CNT_W'(WB_DEPTH));
  assign cpu_stall = cpu_req && (cpu_we ? full : !hit);
  assign line_rd   = data_q[idx];
  assign cpu_rdata = line_rd[wsel*WORD_W +: WORD_W];

  assign push       = cpu_req && cpu_we && !full;
  assign pop        = mem_req && mem_we && mem_ready;
  assign fill_start = cpu_req && !cpu_we && !hit && (wb_count == '0) && !fill_q;
  assign fill_done  = fill_q && mem_ready;

  assign mem_req   = fill_q || (wb_count != '0);
  assign mem_we    = !fill_q;
  assign mem_addr  = fill_q ? {tag, idx, {(WSEL_W+OFF_W){1'b0}}}
                            : {wb_addr[rd_ptr][ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  assign mem_wdata = wb_data[rd_ptr];

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(WB_DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q  <= '0;
      fill_q   <= 1'b0;
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      wb_count <= '0;
    end else begin
      if (fill_done) begin
        valid_q[idx] <= 1'b1;
        fill_q       <= 1'b0;
      end else if (fill_start) begin
        fill_q <= 1'b1;
      end
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      wb_count <= wb_count + CNT_W'(push) - CNT_W'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      wb_addr[wr_ptr] <= cpu_addr;
      wb_data[wr_ptr] <= cpu_wdata;
    end
    if (fill_done) begin
      data_q[idx] <= mem_rdata;
      tag_q[idx]  <= tag;
    end else if (push && hit) begin
      data_q[idx][wsel*WORD_W +: WORD_W] <= cpu_wdata;
    end
  end
endmodule

module wt_dcache_chk #(
  parameter int ADDR_W = 32,
  parameter int DEPTH  = 4,
  parameter int CNT_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_req,
  input logic              cpu_we,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic              cpu_stall,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ready,
  input logic [CNT_W-1:0]  wb_count
);
  assert_wb_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wb_count <= CNT_W'(DEPTH));

  assert_full_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && cpu_we && wb_count == CNT_W'(DEPTH)) |-> cpu_stall);

  assert_fill_after_drain_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we) |-> (wb_count == '0));

  assert_fill_aligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we) |-> (mem_addr[4:0] == 5'd0));

  assert_req_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  assert_fill_serves_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we && mem_ready && cpu_req && !cpu_we)
      |=> (!cpu_req || cpu_we || !$stable(cpu_addr) || !cpu_stall));

  assert_idle_no_stall_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_req |-> !cpu_stall);
endmodule

bind wt_dcache wt_dcache_chk #(.ADDR_W(ADDR_W), .DEPTH(WB_DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
  .cpu_stall(cpu_stall), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
  .mem_ready(mem_ready), .wb_count(wb_count)
);

// File: tb/wt_dcache_bench.sv
module wt_dcache_bench;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         cpu_req, cpu_we;
  logic [31:0]  cpu_addr, cpu_wdata, cpu_rdata;
  logic         cpu_stall;
  logic         mem_req, mem_we;
  logic [31:0]  mem_addr, mem_wdata;
  logic [255:0] mem_rdata;
  logic         mem_ready;

  always #5 clk = ~clk;

  wt_dcache u_wt_dcache (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_stall(cpu_stall),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ready(mem_ready)
  );

  int vectors = 0;
  int fails   = 0;

  bit [31:0] arch [bit [31:0]];
  bit [31:0] phys [bit [31:0]];
  bit        mvalid [256];
  bit [18:0] mtag   [256];
  bit [31:0] q_addr [$];
  bit [31:0] q_data [$];
  bit        mfill;
  bit [31:0] fill_addr;
  int        wait_cnt;

  bit        op_we    [$];
  bit [31:0] op_addr  [$];
  bit [31:0] op_wdata [$];
  int        op_lat   [$];
  string     op_tag   [$];

  function automatic bit [31:0] seed_word(bit [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
  endfunction

  function automatic bit [31:0] arch_rd(bit [31:0] a);
    return arch.exists(a) ? arch[a] : seed_word(a);
  endfunction

  function automatic bit [31:0] phys_rd(bit [31:0] a);
    return phys.exists(a) ? phys[a] : seed_word(a);
  endfunction

  task automatic add(bit we, bit [31:0] a, bit [31:0] d, int lat, string tag);
    op_we.push_back(we); op_addr.push_back(a); op_wdata.push_back(d);
    op_lat.push_back(lat); op_tag.push_back(tag);
  endtask

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
    end
  endtask

  initial begin
    bit [31:0] base [4];
    base[0] = 32'h0000_1040; base[1] = 32'h0000_3040;
    base[2] = 32'h0000_5000; base[3] = 32'h0000_0000;

    add(0, 32'h0000_1040, 0, 2, "R1");
    add(0, 32'h0000_1044, 0, 2, "R2");
    add(0, 32'h0000_105C, 0, 2, "R2");
    add(0, 32'h0000_1048, 0, 2, "R3");
    add(1, 32'h0000_1048, 32'h1111_2222, 3, "R7");
    add(0, 32'h0000_1048, 0, 3, "R7");
    add(1, 32'h0004_2004, 32'hCAFE_0001, 3, "R6");
    add(0, 32'h0004_2004, 0, 3, "R6");
    add(0, 32'h0000_3040, 0, 1, "R11");
    add(0, 32'h0000_1048, 0, 1, "R11");
    for (int i = 0; i < 6; i++)
      add(1, 32'h0000_7000 + 32'(i * 36), 32'hB000_0000 + 32'(i), 6, "R8");
    add(0, 32'h0000_7024, 0, 2, "R4");
    add(1, 32'h0000_1040, 32'h0BAD_F00D, 8, "R10");
    add(0, 32'h0000_1044, 0, 8, "R10");
    add(0, 32'h0000_1040, 0, 8, "R10");
    for (int i = 0; i < 300; i++)
      add(1'($urandom_range(0, 1)), base[$urandom_range(0, 3)] + 32'(4 * $urandom_range(0, 7)),
          $urandom, $urandom_range(0, 3), "R4");
  end

  initial begin
    int k = 0, idle = 0, cycles = 0;
    bit watchdog = 0;
    rst_n = 0; cpu_req = 0; cpu_we = 0; cpu_addr = 0; cpu_wdata = 0;
    mem_ready = 0; mem_rdata = '0;
    mfill = 0; wait_cnt = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    #2;
    chk("R1", "stall after reset", {31'd0, cpu_stall}, 32'd0);
    chk("R1", "mem_req after reset", {31'd0, mem_req}, 32'd0);

    while (k < op_we.size() || idle < 40) begin
      bit [7:0]  ix;
      bit [18:0] tg;
      bit exp_hit, exp_stall, exp_memreq, ready, start_fill;
      bit [31:0] exp_maddr;
      bit [255:0] line;
      string tag;
      int lat;
      @(negedge clk);
      cycles++;
      if (cycles > 60000) begin
        watchdog = 1;
        break;
      end
      if (k < op_we.size()) begin
        cpu_req = 1; cpu_we = op_we[k]; cpu_addr = op_addr[k]; cpu_wdata = op_wdata[k];
        lat = op_lat[k]; tag = op_tag[k];
      end else begin
        cpu_req = 0; cpu_we = 0; lat = 1; tag = "R5"; idle++;
      end
      #1;
      ix = cpu_addr[12:5];
      tg = cpu_addr[31:13];
      exp_hit    = mvalid[ix] && (mtag[ix] == tg);
      exp_stall  = cpu_req && (cpu_we ? (q_addr.size() == 4) : !exp_hit);
      exp_memreq = mfill || (q_addr.size() != 0);
      ready      = exp_memreq && (wait_cnt >= lat);
      if (mfill) for (int w = 0; w < 8; w++) line[w*32 +: 32] = phys_rd(fill_addr + 32'(4 * w));
      else line = '0;
      mem_ready = ready;
      mem_rdata = line;
      #1;
      chk(cpu_we ? "R8" : tag, "cpu_stall", {31'd0, cpu_stall}, {31'd0, exp_stall});
      chk("R9", "mem_req", {31'd0, mem_req}, {31'd0, exp_memreq});
      if (exp_memreq) begin
        exp_maddr = mfill ? fill_addr : q_addr[0];
        chk("R9", "mem_we", {31'd0, mem_we}, {31'd0, !mfill});
        chk(mfill ? "R3" : "R5", "mem_addr", mem_addr, exp_maddr);
        if (!mfill) chk("R5", "mem_wdata", mem_wdata, q_data[0]);
      end
      if (cpu_req && !cpu_we && !exp_stall)
        chk(tag, "cpu_rdata", cpu_rdata, arch_rd({cpu_addr[31:2], 2'b00}));

      start_fill = cpu_req && !cpu_we && !exp_hit && (q_addr.size() == 0) && !mfill;
      if (ready && mfill) begin
        mvalid[fill_addr[12:5]] = 1;
        mtag[fill_addr[12:5]]   = fill_addr[31:13];
        mfill = 0;
      end else if (ready) begin
        phys[q_addr[0]] = q_data[0];
        void'(q_addr.pop_front());
        void'(q_data.pop_front());
      end else if (start_fill) begin
        mfill = 1;
        fill_addr = {cpu_addr[31:5], 5'd0};
      end
      wait_cnt = ready ? 0 : (exp_memreq ? wait_cnt + 1 : 0);
      if (cpu_req && cpu_we && !exp_stall) begin
        q_addr.push_back({cpu_addr[31:2], 2'b00});
        q_data.push_back(cpu_wdata);
        arch[{cpu_addr[31:2], 2'b00}] = cpu_wdata;
      end
      if (cpu_req && !exp_stall) k++;
    end

    if (watchdog) begin
      vectors++;
      fails++;
      $display("FAIL R4 watchdog: actual timeout expected completion of %0d ops", op_we.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule